// File: doc/BRIEF.md
# Dual-Channel Memory-to-Memory DMA Engine

This block moves data between two memory regions without processor involvement. It has two independent channels. Each channel holds a source pointer, a destination pointer, a unit count and a control word. Software fills these through a word-addressed register port. A channel with a nonzero count then copies its units one at a time over a single memory-master port. Each unit is one read, then one write of the data that was read. After each unit the pointers step as the channel's control bits request and the count goes down.

When a channel's count reaches zero, the channel sets its transfer-end flag. If interrupts are enabled for that channel, it also raises an interrupt request. The request carries a 4-bit priority level and that channel's own 7-bit vector. A shared operation register holds three things: the global enable, two fault status flags that halt all activity, and the choice between fixed and round-robin arbitration. Arbitration takes place only between units.

Top module: `dual_dma_engine`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `mem_req` is 0. The register map, with word index in `reg_addr`, is: channel c uses source at 4c, destination at 4c+1, count at 4c+2 and control at 4c+3; vector 0 is at 8, vector 1 at 9, level at 10 and operation at 11.
- R2: Control bits [15:14] step the destination and bits [13:12] step the source. The value 2'b10 subtracts the unit size after each unit, 2'b01 adds it, and 2'b00 or 2'b11 leaves the pointer unchanged.
- R3: Control bits [11:10] select the unit: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes. Each unit is one read at the source (`mem_we`=0), then one write of the same data at the destination (`mem_we`=1). Data is little-endian in the low bytes of the data bus, and `mem_size` carries the unit code. While a write waits for `mem_ack`, its address and data stay stable.
- R4: For unit codes 0 to 2, each unit lowers the count by 1. When the count reaches 0, control bit 1 (transfer end) is set.
- R5: In 16-byte mode each block adds 16 to the source whatever bits [13:12] hold. Each block lowers the count by 4, and a count below 4 goes to 0.
- R6: `irq` is high while any channel has both transfer end and control bit 2 (interrupt enable) set. `irq_level` is bits [3:0] of the level register. `irq_vector` is bits [6:0] of the vector register of the pending channel. When both channels are pending, channel 0's vector is used.
- R7: Writing 0 to transfer end clears it and drops that channel's request. Writing 1 to it keeps its current value, so software can never set it.
- R8: A channel starts units only while all of the following hold: its control bit 0 (channel enable) is 1, operation bit 0 (global enable) is 1, operation bit 1 (NMI flag) is 0, operation bit 2 (address-error flag) is 0, and its transfer end is 0.
- R9: With operation bit 3 = 0 and both channels ready, channel 0 is always granted first.
- R10: With operation bit 3 = 1 and both channels ready, grants alternate between the channels, one unit per grant.
- R11: A channel whose count is 0 issues no memory access and does not set transfer end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Unit code of the access |
| mem_wdata | output | 128 | Write data |
| mem_rdata | input | 128 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes in this cycle |
| irq | output | 1 | Interrupt request |
| irq_level | output | 4 | Interrupt priority level |
| irq_vector | output | 7 | Interrupt vector |

## Verification
The embedded assertions check four things on every cycle. An access starts only when the global enable was set. A write's address and data stay still while it waits for acknowledge. A count never rises unless software writes it. Transfer end appears only when the count is zero. The bench scenarios cover what needs a whole transfer to show. They compare the copied memory image and the final pointers against a byte-level model for every unit size and step mode. They also check the 16-byte source rule, the interrupt level and vector selection, the clearing and setting of transfer end, the gating flags, and the read order under each arbitration mode.

// File: rtl/dual_dma_engine.sv
module dual_dma_engine #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 128,
  parameter int RA = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [RA-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          irq,
  output logic [3:0]    irq_level,
  output logic [6:0]    irq_vector
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_UPD} st_t;

  st_t           st;
  logic [AW-1:0] src_q [2];
  logic [AW-1:0] dst_q [2];
  logic [CW-1:0] cnt_q [2];
  logic [15:0]   ctl_q [2];
  logic [7:0]    vec_q [2];
  logic [3:0]    lvl_q, op_q;
  logic          cur, last;
  logic [DW-1:0] buf_q;
  logic [1:0]    rdy, pend;
  logic          pick;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    assign rdy[g]  = ctl_q[g][0] & ~ctl_q[g][1] & op_q[0] & ~op_q[1] & ~op_q[2]
                     & (cnt_q[g] != '0);
    assign pend[g] = ctl_q[g][1] & ctl_q[g][2];
  end

  assign pick = (&rdy) ? (op_q[3] & ~last) : rdy[1];

  logic [1:0]    usz;
  logic [AW-1:0] step, nxt_src, nxt_dst;
  logic [CW-1:0] nxt_cnt;

  assign usz  = ctl_q[cur][11:10];
  assign step = (usz == 2'd3) ? AW'(16) : (AW'(1) << usz);

  always_comb begin
    case (ctl_q[cur][15:14])
      2'b10:   nxt_dst = dst_q[cur] - step;
      2'b01:   nxt_dst = dst_q[cur] + step;
      default: nxt_dst = dst_q[cur];
    endcase
    if (usz == 2'd3) nxt_src = src_q[cur] + AW'(16);
    else begin
      case (ctl_q[cur][13:12])
        2'b10:   nxt_src = src_q[cur] - step;
        2'b01:   nxt_src = src_q[cur] + step;
        default: nxt_src = src_q[cur];
      endcase
    end
    if (usz == 2'd3) nxt_cnt = (cnt_q[cur] < CW'(4)) ? '0 : cnt_q[cur] - CW'(4);
    else             nxt_cnt = cnt_q[cur] - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cur   <= 1'b0;
      last  <= 1'b1;
      buf_q <= '0;
      lvl_q <= '0;
      op_q  <= '0;
      for (int c = 0; c < 2; c++) begin
        src_q[c] <= '0;
        dst_q[c] <= '0;
        cnt_q[c] <= '0;
        ctl_q[c] <= '0;
        vec_q[c] <= '0;
      end
    end else begin
      if (reg_we) begin
        for (int c = 0; c < 2; c++) begin
          if (reg_addr == RA'(4*c))     src_q[c] <= reg_wdata[AW-1:0];
          if (reg_addr == RA'(4*c + 1)) dst_q[c] <= reg_wdata[AW-1:0];
          if (reg_addr == RA'(4*c + 2)) cnt_q[c] <= reg_wdata[CW-1:0];
          if (reg_addr == RA'(4*c + 3))
            ctl_q[c] <= {reg_wdata[15:2], reg_wdata[1] & ctl_q[c][1], reg_wdata[0]};
          if (reg_addr == RA'(8 + c))   vec_q[c] <= reg_wdata[7:0];
        end
        if (reg_addr == RA'(10)) lvl_q <= reg_wdata[3:0];
        if (reg_addr == RA'(11)) op_q  <= reg_wdata[3:0];
      end
      case (st)
        S_IDLE: if (|rdy) begin
          cur  <= pick;
          last <= pick;
          st   <= S_RD;
        end
        S_RD: if (mem_ack) begin
          buf_q <= mem_rdata;
          st    <= S_WR;
        end
        S_WR: if (mem_ack) st <= S_UPD;
        default: begin
          src_q[cur] <= nxt_src;
          dst_q[cur] <= nxt_dst;
          cnt_q[cur] <= nxt_cnt;
          if (nxt_cnt == '0) ctl_q[cur][1] <= 1'b1;
          st <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA'(0):  reg_rdata = 32'(src_q[0]);
      RA'(1):  reg_rdata = 32'(dst_q[0]);
      RA'(2):  reg_rdata = 32'(cnt_q[0]);
      RA'(3):  reg_rdata = 32'(ctl_q[0]);
      RA'(4):  reg_rdata = 32'(src_q[1]);
      RA'(5):  reg_rdata = 32'(dst_q[1]);
      RA'(6):  reg_rdata = 32'(cnt_q[1]);
      RA'(7):  reg_rdata = 32'(ctl_q[1]);
      RA'(8):  reg_rdata = 32'(vec_q[0]);
      RA'(9):  reg_rdata = 32'(vec_q[1]);
      RA'(10): reg_rdata = 32'(lvl_q);
      RA'(11): reg_rdata = 32'(op_q);
      default: reg_rdata = '0;
    endcase
  end

  assign mem_req    = (st == S_RD) || (st == S_WR);
  assign mem_we     = (st == S_WR);
  assign mem_addr   = (st == S_WR) ? dst_q[cur] : src_q[cur];
  assign mem_size   = usz;
  assign mem_wdata  = buf_q;
  assign irq        = |pend;
  assign irq_level  = lvl_q;
  assign irq_vector = pend[0] ? vec_q[0][6:0] : vec_q[1][6:0];

  a_r8_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(op_q[0]) && !mem_we);

  a_r3_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_addr) && $stable(mem_wdata) && mem_we);

  a_r4_count_ch0_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we) |-> cnt_q[0] <= $past(cnt_q[0]));

  a_r4_count_ch1_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we) |-> cnt_q[1] <= $past(cnt_q[1]));

  a_r7_end_ch0_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[0][1]) |-> cnt_q[0] == '0);

  a_r7_end_ch1_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[1][1]) |-> cnt_q[1] == '0);

endmodule

// File: tb/dual_dma_engine_test.sv
`timescale 1ns/1ps
module dual_dma_engine_test;
  logic         clk = 0, rst_n = 0;
  logic         reg_we = 0;
  logic [3:0]   reg_addr = 0;
  logic [31:0]  reg_wdata = 0, reg_rdata;
  logic         mem_req, mem_we, mem_ack = 0;
  logic [31:0]  mem_addr;
  logic [1:0]   mem_size;
  logic [127:0] mem_wdata, mem_rdata = 0;
  logic         irq;
  logic [3:0]   irq_level;
  logic [6:0]   irq_vector;

  int checks = 0, fails = 0;
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [31:0] rlog [64];
  int rlog_n = 0;
  int req_cycles = 0;

  dual_dma_engine uut (.*);

  always #4 clk = ~clk;

  function automatic int ubytes(logic [1:0] z);
    return (z == 2'd3) ? 16 : (1 << z);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8ns * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req) req_cycles++;
      if (mem_req && ($urandom % 4 != 0)) begin
        mem_ack = 1;
        if (!mem_we) begin
          mem_rdata = '0;
          for (int k = 0; k < ubytes(mem_size); k++)
            mem_rdata[8*k +: 8] = mem[8'(mem_addr[7:0] + 8'(k))];
          if (rlog_n < 64) rlog[rlog_n] = mem_addr;
          rlog_n++;
        end else begin
          for (int k = 0; k < ubytes(mem_size); k++)
            mem[8'(mem_addr[7:0] + 8'(k))] = mem_wdata[8*k +: 8];
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 4'(a); #1 d = reg_rdata;
  endtask

  task automatic wait_done(input int ch, string req);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(ch*4 + 3, v);
      if (v[1]) return;
    end
    chk(req, "transfer end never set", 0, 1);
  endtask

  task automatic run_one(input int ch, input logic [1:0] usz, input logic [1:0] dm,
                         input logic [1:0] sm, input int n, input logic [31:0] s,
                         input logic [31:0] d, input bit ie, input bit keep);
    logic [31:0] ps, pd, v, step;
    logic [7:0] tmp [16];
    int c, bad;
    shadow = mem; ps = s; pd = d; c = n; step = ubytes(usz);
    while (c > 0) begin
      for (int k = 0; k < int'(step); k++) tmp[k] = shadow[8'(ps[7:0] + 8'(k))];
      for (int k = 0; k < int'(step); k++) shadow[8'(pd[7:0] + 8'(k))] = tmp[k];
      if (dm == 2'b10) pd = pd - step; else if (dm == 2'b01) pd = pd + step;
      if (usz == 2'd3) ps = ps + 16;
      else if (sm == 2'b10) ps = ps - step; else if (sm == 2'b01) ps = ps + step;
      if (usz == 2'd3) c = (c < 4) ? 0 : c - 4; else c = c - 1;
    end
    wr(ch*4, s); wr(ch*4 + 1, d); wr(ch*4 + 2, n);
    wr(ch*4 + 3, {16'd0, dm, sm, usz, 7'd0, ie, 1'b0, 1'b1});
    wait_done(ch, "R4");
    repeat (2) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
    chk("R3", "mismatched bytes", bad, 0);
    rd(ch*4, v);     chk("R2", "final source", v, ps);
    rd(ch*4 + 1, v); chk("R2", "final destination", v, pd);
    rd(ch*4 + 2, v); chk("R4", "final count", v, 0);
    if (!keep) wr(ch*4 + 3, 0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      rd(a, v); chk("R1", $sformatf("register %0d after reset", a), v, 0);
    end
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "mem_req after reset", mem_req, 0);

    // R8 gating by global enable and fault flags
    wr(0, 32'h10); wr(1, 32'h90); wr(2, 3); wr(3, 32'h5001);
    for (int f = 0; f < 3; f++) begin
      wr(11, (f == 0) ? 0 : (f == 1 ? 32'h3 : 32'h5));
      req_cycles = 0;
      repeat (40) @(negedge clk);
      chk("R8", $sformatf("requests while gated %0d", f), req_cycles, 0);
      rd(2, v); chk("R8", "count while gated", v, 3);
    end
    wr(11, 1);
    wait_done(0, "R8");
    rd(2, v); chk("R8", "count after ungating", v, 0);
    wr(3, 0);

    // R11 zero count
    wr(6, 0); wr(7, 32'h5001);
    req_cycles = 0;
    repeat (40) @(negedge clk);
    chk("R11", "requests with zero count", req_cycles, 0);
    rd(7, v); chk("R11", "transfer end with zero count", v[1], 0);
    wr(7, 0);

    // R2 R3 R4 random transfers
    for (int t = 0; t < 30; t++) begin
      logic [1:0] z;
      z = 2'($urandom);
      run_one($urandom % 2, z, 2'($urandom), 2'($urandom),
              1 + $urandom % ((z == 2'd3) ? 12 : 8),
              $urandom % 256, $urandom % 256, 0, 0);
    end

    // R5 block mode: count 6 -> two blocks, source +16 despite decrement bits
    run_one(0, 2'd3, 2'b01, 2'b10, 6, 32'h20, 32'h80, 0, 0);
    rd(0, v); chk("R5", "block source after count 6", v, 32'h40);
    rd(1, v); chk("R5", "block destination after count 6", v, 32'hA0);

    // R2 both step bits set -> fixed
    run_one(1, 2'd1, 2'b11, 2'b11, 4, 32'h30, 32'hB0, 0, 0);
    rd(4, v); chk("R2", "source fixed with 2'b11", v, 32'h30);

    // R6 interrupt level and vector
    wr(8, 32'hFF); wr(9, 32'h35); wr(10, 32'h1A);
    chk("R6", "irq before completion", irq, 0);
    run_one(1, 2'd0, 2'b01, 2'b01, 2, 32'h00, 32'h60, 1, 1);
    @(negedge clk);
    chk("R6", "irq ch1", irq, 1);
    chk("R6", "level", irq_level, 4'hA);
    chk("R6", "vector ch1", irq_vector, 7'h35);
    run_one(0, 2'd2, 2'b01, 2'b01, 2, 32'h08, 32'h70, 1, 1);
    @(negedge clk);
    chk("R6", "vector both pending (ch0 masked)", irq_vector, 7'h7F);
    // R7 clear and no-set
    wr(3, 0);
    @(negedge clk);
    chk("R7", "vector after ch0 cleared", irq_vector, 7'h35);
    chk("R7", "irq still from ch1", irq, 1);
    wr(3, 32'h2);
    rd(3, v); chk("R7", "writing 1 to end flag", v[1], 0);
    wr(7, 32'h0004 | 32'h2);
    rd(7, v); chk("R7", "end flag kept by writing 1", v[1], 1);
    wr(7, 0);
    @(negedge clk);
    chk("R7", "irq after clearing", irq, 0);

    // R9 fixed priority
    wr(11, 0);
    wr(0, 32'h00); wr(1, 32'h80); wr(2, 3); wr(3, 32'h5001);
    wr(4, 32'h40); wr(5, 32'hC0); wr(6, 3); wr(7, 32'h5001);
    rlog_n = 0;
    wr(11, 1);
    wait_done(0, "R9"); wait_done(1, "R9");
    for (int i = 0; i < 6; i++)
      chk("R9", $sformatf("fixed order read %0d", i), rlog[i],
          (i < 3) ? 32'(i) : 32'(32'h40 + i - 3));
    wr(3, 0); wr(7, 0);

    // R10 round robin
    wr(11, 0);
    wr(0, 32'h00); wr(1, 32'h80); wr(2, 3); wr(3, 32'h5001);
    wr(4, 32'h40); wr(5, 32'hC0); wr(6, 3); wr(7, 32'h5001);
    rlog_n = 0;
    wr(11, 32'h9);
    wait_done(0, "R10"); wait_done(1, "R10");
    chk("R10", "reads recorded", rlog_n, 6);
    for (int i = 1; i < 6; i++)
      chk("R10", $sformatf("alternation at read %0d", i), rlog[i][6] ^ rlog[i-1][6], 1);
    wr(3, 0); wr(7, 0);

    summary();
  end
endmodule